// File: doc/BRIEF.md
# Indirect PCI Configuration Access Bridge

A local processor reaches a PCI bus through this bridge one transaction at a time, by writing a small set of registers. The bridge has an address register, a command register, a write-data register, a read-data register and a status register. A read starts when the command register is written with a read command. A write starts when the write-data register is written while the stored command is a write command. The bridge then drives one single-beat request on its bus port and holds it until the target side acknowledges. The acknowledge also reports whether any target claimed the access.

Next to the register path sits a combinational request encoder. From bus number, slot, function, register offset and access size, it forms the configuration address, which is Type 0 on bus 0 and Type 1 elsewhere, and the active-low byte-enable nibble. It also places a write value on its byte lanes and extracts the addressed field from the read-data register. An unclaimed access sets a sticky abort flag, and software clears that flag by writing one to it. A build option repeats every read eight times and keeps only the last result.

Top module: `cfg_bridge`

## Requirements
- R1: Writing the command register (select 1) with an even command code (bit 0 = 0) while idle starts a read. The read-data register (select 3) holds the returned data from the edge on which the acknowledge is sampled.
- R2: Writing the command register with an odd command code starts nothing. Writing the write-data register (select 2) while the stored code is odd starts one write request that carries the address register, command bits [3:0], enables from bits [7:4] and the written data. A write leaves the read-data register unchanged.
- R3: Encoder byte enables are active low. Size 4 gives 0000, size 1 at lane n clears bit n only, and size 2 at lane n clears bits n and n+1 (bits above 3 are dropped). Lane n is offset bits [1:0].
- R4: An encoder size other than 1, 2 or 4 raises the bad-size flag and gives enables 1111.
- R5: On bus 0 the encoder address is Type 0. It holds function in [10:8], offset[7:2] in [7:2], zeros in [1:0], and a single select bit at 32 minus the slot for slots 1 to 21; other slots get no select bit.
- R6: On a non-zero bus the encoder address is Type 1. It holds bus in [23:16], slot in [15:11], function in [10:8], offset[7:2] in [7:2], bit 1 = 0 and bit 0 = 1.
- R7: The lane-placed write value is the input shifted left by 8·n. The read field is the read-data register shifted right by 8·n and masked to 8, 16 or 32 bits by size, or zero for a bad size.
- R8: An unclaimed access sets status bit 0 (select 4). Writing 1 to that bit clears it and writing 0 leaves it set.
- R9: A read that no target claims loads all ones into the read-data register.
- R10: Busy (port and status bit 1) is high from the edge after a launching write until the edge that samples the acknowledge. Register writes made while busy have no effect.
- R11: With the repeated-read option on, a read issues 8 requests with one idle cycle between them. The read-data register keeps the data from the eighth request.
- R12: Once the bridge raises its request, the request and its address, command and enables hold steady until the acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 addr, 1 command, 2 write data, 3 read data, 4 status |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Selected register value |
| busy | output | 1 | Transaction in flight |
| bus_req | output | 1 | Request to the PCI side |
| bus_write | output | 1 | Request is a write |
| bus_addr | output | 32 | Request address |
| bus_cmd | output | 4 | PCI command code |
| bus_be | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Response strobe |
| bus_claimed | input | 1 | A target claimed the access |
| bus_rdata | input | 32 | Response data |
| cfg_bus | input | 8 | Encoder bus number |
| cfg_slot | input | 5 | Encoder slot number |
| cfg_fn | input | 3 | Encoder function number |
| cfg_off | input | 8 | Encoder register byte offset |
| cfg_size | input | 3 | Encoder access size in bytes |
| cfg_wval | input | 32 | Value to place on byte lanes |
| cfg_addr | output | 32 | Configuration address |
| cfg_be | output | 4 | Active-low byte enables |
| cfg_bad | output | 1 | Unsupported access size |
| cfg_wlane | output | 32 | Lane-placed write value |
| cfg_rfield | output | 32 | Field taken from the read-data register |

## Verification
The encoder outputs are combinational, so they are compared a moment after their inputs settle, within the same cycle. A launching register write raises busy and the request on the next edge. When the bench target acknowledges after d wait cycles, busy falls and the read-data and status registers update on the edge that samples the acknowledge, d+1 edges after launch. A model in the bench counts those edges and compares busy at every falling edge. Register contents are read back only after that edge. In repeated-read mode the result is due 15 edges after launch.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_GAP} sq_state_t;
   localparam logic [2:0] SEL_ADDR = 3'd0;
   localparam logic [2:0] SEL_CTRL = 3'd1;
   localparam logic [2:0] SEL_WDAT = 3'd2;
   localparam logic [2:0] SEL_RDAT = 3'd3;
   localparam logic [2:0] SEL_STAT = 3'd4;
endpackage

// File: rtl/cfgb_encode.sv
module cfgb_encode #(
   parameter int DW = 32
) (
   input  logic [7:0]    bus_num,
   input  logic [4:0]    slot,
   input  logic [2:0]    fn,
   input  logic [7:0]    off,
   input  logic [2:0]    size,
   input  logic [DW-1:0] wval,
   input  logic [DW-1:0] rsrc,
   output logic [DW-1:0] addr,
   output logic [3:0]    be,
   output logic          bad,
   output logic [DW-1:0] wlane,
   output logic [DW-1:0] rfield
);
   localparam int LANES = DW / 8;
   logic [1:0]    lane;
   logic [4:0]    shamt;
   logic [4:0]    m5;
   logic [DW-1:0] rmask;
   logic [DW-1:0] sel_bit;

   assign lane  = off[1:0];
   assign shamt = {lane, 3'b000};

   always_comb begin
      bad = 1'b0;
      case (size)
         3'd1:    begin m5 = 5'b00001 << lane; rmask = DW'(32'h0000_00FF); end
         3'd2:    begin m5 = 5'b00011 << lane; rmask = DW'(32'h0000_FFFF); end
         3'd4:    begin m5 = 5'b01111;         rmask = '1; end
         default: begin m5 = 5'b00000;         rmask = '0; bad = 1'b1; end
      endcase
      be = ~m5[3:0];
   end

   always_comb begin
      sel_bit = '0;
      for (int k = 11; k < DW; k++) begin
         if (int'(slot) == DW - k) sel_bit[k] = 1'b1;
      end
   end

   always_comb begin
      if (bus_num == 8'd0)
         addr = sel_bit | DW'({fn, off[7:2], 2'b00});
      else
         addr = DW'({bus_num, slot, fn, off[7:2], 2'b01});
   end

   assign wlane  = wval << shamt;
   assign rfield = (rsrc >> shamt) & rmask;

   always_comb begin
      if (bad) begin
         AST_BAD_NO_BE: assert (be == 4'hF) else $error("bad size enabled a lane"); // R4
      end
      if (bus_num == 8'd0) begin
         AST_TYPE0_ONEHOT: assert ($onehot0(addr[DW-1:11]) && addr[1:0] == 2'b00) else $error("type0 select"); // R5
      end
      if (!bad && (int'(lane) + int'(size) <= LANES)) begin
         AST_BE_COUNT: assert ($countones(~be) == int'(size)) else $error("enable count"); // R3
      end
   end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
   import cfgb_pkg::*;
#(
   parameter int DW            = 32,
   parameter bit ERRATA_RD     = 1'b0,
   parameter int ERRATA_PASSES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_wr,
   input  logic [DW-1:0] start_addr,
   input  logic [3:0]    start_cmd,
   input  logic [3:0]    start_be,
   input  logic [DW-1:0] start_wdata,
   output logic          busy,
   output logic          done,
   output logic          done_write,
   output logic          done_abort,
   output logic [DW-1:0] done_data,
   output logic          bus_req,
   output logic          bus_write,
   output logic [DW-1:0] bus_addr,
   output logic [3:0]    bus_cmd,
   output logic [3:0]    bus_be,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic          bus_claimed,
   input  logic [DW-1:0] bus_rdata
);
   localparam int NPASS = ERRATA_RD ? ERRATA_PASSES : 1;
   localparam int PW    = (NPASS > 1) ? $clog2(NPASS) : 1;

   sq_state_t     st;
   logic [PW-1:0] pass_q;
   logic          ab_q;
   logic          last;

   generate
      if (ERRATA_RD) begin : g_repeat
         assign last = bus_write | (pass_q == PW'(NPASS - 1));
      end else begin : g_single
         assign last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         pass_q    <= '0;
         ab_q      <= 1'b0;
         bus_write <= 1'b0;
         bus_addr  <= '0;
         bus_cmd   <= '0;
         bus_be    <= 4'hF;
         bus_wdata <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (start) begin
               st        <= SQ_REQ;
               pass_q    <= '0;
               ab_q      <= 1'b0;
               bus_write <= start_wr;
               bus_addr  <= start_addr;
               bus_cmd   <= start_cmd;
               bus_be    <= start_be;
               bus_wdata <= start_wdata;
            end
            SQ_REQ: if (bus_ack) begin
               ab_q <= ab_q | ~bus_claimed;
               if (last) st <= SQ_IDLE;
               else begin
                  st     <= SQ_GAP;
                  pass_q <= pass_q + 1'b1;
               end
            end
            default: st <= SQ_REQ;
         endcase
      end
   end

   assign busy       = (st != SQ_IDLE);
   assign bus_req    = (st == SQ_REQ);
   assign done       = bus_req & bus_ack & last;
   assign done_write = bus_write;
   assign done_abort = ab_q | ~bus_claimed;
   assign done_data  = bus_rdata;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_be))) // R12
      else $error("request dropped or changed before ack");
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && bus_write) |=> !bus_req) // R2
      else $error("write reissued");
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
   import cfgb_pkg::*;
#(
   parameter int DW            = 32,
   parameter bit ERRATA_RD     = 1'b0,
   parameter int ERRATA_PASSES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          busy,
   output logic          bus_req,
   output logic          bus_write,
   output logic [DW-1:0] bus_addr,
   output logic [3:0]    bus_cmd,
   output logic [3:0]    bus_be,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic          bus_claimed,
   input  logic [DW-1:0] bus_rdata,
   input  logic [7:0]    cfg_bus,
   input  logic [4:0]    cfg_slot,
   input  logic [2:0]    cfg_fn,
   input  logic [7:0]    cfg_off,
   input  logic [2:0]    cfg_size,
   input  logic [DW-1:0] cfg_wval,
   output logic [DW-1:0] cfg_addr,
   output logic [3:0]    cfg_be,
   output logic          cfg_bad,
   output logic [DW-1:0] cfg_wlane,
   output logic [DW-1:0] cfg_rfield
);
   generate
      if (DW != 32) begin : g_bad_dw
         $error("cfg_bridge: DW must be 32");
      end
      if (ERRATA_RD && ERRATA_PASSES < 2) begin : g_bad_passes
         $error("cfg_bridge: repeated reads need at least 2 passes");
      end
   endgenerate

   logic [DW-1:0] addr_q, wdata_q, rdata_q;
   logic [7:0]    ctrl_q;
   logic          abort_q;
   logic          accept, start_rd, start_wr, w1c;
   logic          done, done_write, done_abort;
   logic [DW-1:0] done_data;

   assign accept   = reg_wr & ~busy;
   assign start_rd = accept & (reg_sel == SEL_CTRL) & ~reg_wdata[0];
   assign start_wr = accept & (reg_sel == SEL_WDAT) & ctrl_q[0];
   assign w1c      = accept & (reg_sel == SEL_STAT) & reg_wdata[0];

   cfgb_seq #(.DW(DW), .ERRATA_RD(ERRATA_RD), .ERRATA_PASSES(ERRATA_PASSES)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(start_rd | start_wr), .start_wr(start_wr),
      .start_addr(addr_q),
      .start_cmd(start_rd ? reg_wdata[3:0] : ctrl_q[3:0]),
      .start_be(start_rd ? reg_wdata[7:4] : ctrl_q[7:4]),
      .start_wdata(reg_wdata),
      .busy(busy), .done(done), .done_write(done_write),
      .done_abort(done_abort), .done_data(done_data),
      .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_cmd(bus_cmd), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_claimed(bus_claimed), .bus_rdata(bus_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         ctrl_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         abort_q <= 1'b0;
      end else begin
         if (accept && reg_sel == SEL_ADDR) addr_q  <= reg_wdata;
         if (accept && reg_sel == SEL_CTRL) ctrl_q  <= reg_wdata[7:0];
         if (accept && reg_sel == SEL_WDAT) wdata_q <= reg_wdata;
         if (done && !done_write) rdata_q <= done_abort ? '1 : done_data;
         abort_q <= (abort_q & ~w1c) | (done & done_abort);
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_ADDR: reg_rdata = addr_q;
         SEL_CTRL: reg_rdata = DW'(ctrl_q);
         SEL_WDAT: reg_rdata = wdata_q;
         SEL_RDAT: reg_rdata = rdata_q;
         SEL_STAT: reg_rdata = DW'({busy, abort_q});
         default:  reg_rdata = '0;
      endcase
   end

   cfgb_encode #(.DW(DW)) u_enc (
      .bus_num(cfg_bus), .slot(cfg_slot), .fn(cfg_fn), .off(cfg_off),
      .size(cfg_size), .wval(cfg_wval), .rsrc(rdata_q),
      .addr(cfg_addr), .be(cfg_be), .bad(cfg_bad),
      .wlane(cfg_wlane), .rfield(cfg_rfield)
   );

   AST_RD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && reg_sel == SEL_CTRL && !reg_wdata[0]) |=> busy) // R1
      else $error("read did not launch");
   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && busy) |=> ($stable(addr_q) && $stable(ctrl_q) && $stable(wdata_q))) // R10
      else $error("register changed while busy");
   AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_q && !(reg_wr && !busy && reg_sel == SEL_STAT && reg_wdata[0])) |=> abort_q) // R8
      else $error("abort flag lost");
   AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_write && done_abort) |=> (rdata_q == '1)) // R9
      else $error("aborted read data not all ones");
endmodule

// File: tb/tb_cfg_bridge.sv
module tb_cfg_bridge;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, e_reg_rdata;
   logic        busy, bus_req, bus_write, e_busy, e_req, e_write;
   logic [31:0] bus_addr, bus_wdata, e_addr, e_wdata;
   logic [3:0]  bus_cmd, bus_be, e_cmd, e_be;
   logic        bus_ack = 1'b0, bus_claimed = 1'b1, e_ack = 1'b0;
   logic [31:0] bus_rdata = '0, e_rdata = '0;
   logic [7:0]  cfg_bus = '0;
   logic [4:0]  cfg_slot = '0;
   logic [2:0]  cfg_fn = '0;
   logic [7:0]  cfg_off = '0;
   logic [2:0]  cfg_size = 3'd4;
   logic [31:0] cfg_wval = '0;
   logic [31:0] cfg_addr, cfg_wlane, cfg_rfield, e_caddr, e_cwl, e_crf;
   logic [3:0]  cfg_be, e_cbe;
   logic        cfg_bad, e_cbad;

   cfg_bridge dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .busy(busy), .bus_req(bus_req), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_claimed(bus_claimed), .bus_rdata(bus_rdata),
      .cfg_bus(cfg_bus), .cfg_slot(cfg_slot), .cfg_fn(cfg_fn), .cfg_off(cfg_off),
      .cfg_size(cfg_size), .cfg_wval(cfg_wval), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_bad(cfg_bad), .cfg_wlane(cfg_wlane), .cfg_rfield(cfg_rfield));

   cfg_bridge #(.ERRATA_RD(1'b1)) dut_rep (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(e_reg_rdata), .busy(e_busy), .bus_req(e_req), .bus_write(e_write),
      .bus_addr(e_addr), .bus_cmd(e_cmd), .bus_be(e_be), .bus_wdata(e_wdata),
      .bus_ack(e_ack), .bus_claimed(1'b1), .bus_rdata(e_rdata),
      .cfg_bus(cfg_bus), .cfg_slot(cfg_slot), .cfg_fn(cfg_fn), .cfg_off(cfg_off),
      .cfg_size(cfg_size), .cfg_wval(cfg_wval), .cfg_addr(e_caddr), .cfg_be(e_cbe),
      .cfg_bad(e_cbad), .cfg_wlane(e_cwl), .cfg_rfield(e_crf));

   int n_vec = 0, n_bad = 0;
   int ack_delay = 0, wcnt = 0;
   logic resp_claim = 1'b1;
   logic [31:0] resp_data = '0;
   logic [31:0] cap_addr, cap_wdata;
   logic [3:0]  cap_cmd, cap_be;
   logic        cap_write, prev_req = 1'b0, prev_ereq = 1'b0;
   int req_rises = 0, e_rises = 0, e_acks = 0, addr_moves = 0;
   int left = 0;
   bit launch_pending = 0, model_on = 0;
   logic [31:0] last_rd = '0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // target model for the main instance
   always @(negedge clk) begin
      if (bus_req && !bus_ack) begin
         if (bus_req && prev_req && bus_addr !== cap_addr) addr_moves++;
         cap_addr = bus_addr; cap_cmd = bus_cmd; cap_be = bus_be;
         cap_write = bus_write; cap_wdata = bus_wdata;
         if (wcnt == ack_delay) begin
            bus_ack = 1'b1; bus_claimed = resp_claim; bus_rdata = resp_data;
         end else wcnt++;
      end else begin
         bus_ack = 1'b0; wcnt = 0;
      end
      if (bus_req && !prev_req) req_rises++;
      prev_req = bus_req;
      if (e_req && !e_ack) begin
         e_ack = 1'b1; e_rdata = 32'hE0 + e_acks; e_acks++;
      end else e_ack = 1'b0;
      if (e_req && !prev_ereq) e_rises++;
      prev_ereq = e_req;
   end

   // cycle model of busy for the main instance
   always @(posedge clk) begin
      if (launch_pending) begin left = ack_delay + 1; launch_pending = 0; end
      else if (left > 0) left--;
   end
   always @(negedge clk) if (model_on) chk("R10 busy", {31'd0, busy}, {31'd0, left > 0});

   task automatic wr(input logic [2:0] s, input logic [31:0] d, input bit launches);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      if (launches) launch_pending = 1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [31:0] v);
      @(negedge clk);
      reg_sel = s; #1;
      v = reg_rdata;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [3:0] exp_be(input int n, input int sz);
      logic [3:0] b = 4'hF;
      if (sz == 1 || sz == 2 || sz == 4)
         for (int i = 0; i < 4; i++) if (i >= n && i < n + sz) b[i] = 1'b0;
      if (sz == 4) b = 4'h0;
      return b;
   endfunction

   task automatic enc(input int bn, input int sl, input int f, input int of, input int sz,
                      input logic [31:0] wv);
      logic [31:0] ea, ef;
      int n;
      n = of % 4;
      cfg_bus = 8'(bn); cfg_slot = 5'(sl); cfg_fn = 3'(f); cfg_off = 8'(of);
      cfg_size = 3'(sz); cfg_wval = wv;
      #1;
      if (bn == 0) begin
         ea = 32'(f * 256 + (of / 4) * 4);
         if (sl >= 1 && sl <= 21) ea = ea | (32'd1 << (32 - sl));
         chk("R5 type0 addr", cfg_addr, ea);
      end else begin
         ea = 32'(bn * 65536 + sl * 2048 + f * 256 + (of / 4) * 4 + 1);
         chk("R6 type1 addr", cfg_addr, ea);
      end
      chk("R3 enables", {28'd0, cfg_be}, {28'd0, exp_be(n, sz)});
      chk("R4 bad size", {31'd0, cfg_bad}, {31'd0, !(sz == 1 || sz == 2 || sz == 4)});
      chk("R7 lane write", cfg_wlane, wv << (8 * n));
      case (sz)
         1: ef = (last_rd >> (8 * n)) & 32'hFF;
         2: ef = (last_rd >> (8 * n)) & 32'hFFFF;
         4: ef = last_rd >> (8 * n);
         default: ef = 32'h0;
      endcase
      chk("R7 read field", cfg_rfield, ef);
   endtask

   bit timed_out = 0;
   initial begin
      #(4 * 200000);
      timed_out = 1;
   end

   initial begin : main
      logic [31:0] v;
      int r0;
      fork
         begin
            waitn(3);
            rst_n = 1'b1;
            waitn(1);
            chk("R10 reset busy", {31'd0, busy}, 32'd0);
            chk("R12 reset req", {31'd0, bus_req}, 32'd0);
            rd(3'd4, v); chk("R8 reset status", v, 32'd0);
            rd(3'd3, v); chk("R1 reset rdata", v, 32'd0);
            model_on = 1;

            // repeated-read option and plain read together
            resp_data = 32'h55AA_0001;
            wr(3'd1, 32'h0000_000A, 1);
            waitn(18);
            chk("R11 pass count", 32'(e_rises), 32'd8);
            reg_sel = 3'd3; #1;
            chk("R11 kept last pass", e_reg_rdata, 32'hE7);
            chk("R1 read data", reg_rdata, 32'h55AA_0001);
            last_rd = 32'h55AA_0001;

            // encoder patterns
            enc(0, 3, 2, 8'h12, 1, 32'hAB);
            enc(5, 9, 1, 8'h3E, 2, 32'h1234);
            enc(0, 21, 0, 8'h40, 4, 32'hDEADBEEF);
            enc(0, 1, 7, 8'hFC, 1, 32'h5A);
            enc(1, 2, 3, 8'h07, 2, 32'hBEEF);
            enc(0, 0, 0, 8'h04, 4, 32'h1);
            enc(2, 0, 0, 8'h08, 3, 32'h77);
            enc(0, 4, 0, 8'h00, 0, 32'h77);

            // read with field checks
            wr(3'd0, 32'h0005_493D, 0);
            resp_data = 32'h1122_3344;
            r0 = req_rises;
            wr(3'd1, 32'h0000_003A, 1);
            waitn(2);
            chk("R1 bus addr", cap_addr, 32'h0005_493D);
            chk("R1 bus cmd", {28'd0, cap_cmd}, 32'hA);
            chk("R3 bus enables", {28'd0, cap_be}, 32'h3);
            chk("R1 bus dir", {31'd0, cap_write}, 32'd0);
            rd(3'd3, v); chk("R1 read data", v, 32'h1122_3344);
            last_rd = 32'h1122_3344;
            enc(0, 5, 0, 8'h01, 1, 32'h0);
            enc(0, 5, 0, 8'h02, 2, 32'h0);
            enc(3, 5, 0, 8'h00, 4, 32'h0);

            // write path
            wr(3'd1, 32'h0000_000B, 0);
            waitn(2);
            r0 = req_rises;
            wr(3'd2, 32'hCAFE_F00D, 1);
            waitn(3);
            chk("R2 one request", 32'(req_rises - r0), 32'd1);
            chk("R2 write dir", {31'd0, cap_write}, 32'd1);
            chk("R2 write data", cap_wdata, 32'hCAFE_F00D);
            chk("R2 write cmd", {28'd0, cap_cmd}, 32'hB);
            chk("R2 write enables", {28'd0, cap_be}, 32'h0);
            rd(3'd3, v); chk("R2 rdata untouched", v, 32'h1122_3344);

            // unclaimed read
            resp_claim = 1'b0;
            wr(3'd1, 32'h0000_002A, 1);
            waitn(2);
            rd(3'd3, v); chk("R9 abort data", v, 32'hFFFF_FFFF);
            rd(3'd4, v); chk("R8 abort set", v & 32'h1, 32'h1);
            wr(3'd4, 32'h0, 0);
            rd(3'd4, v); chk("R8 write zero keeps", v & 32'h1, 32'h1);
            wr(3'd4, 32'h1, 0);
            rd(3'd4, v); chk("R8 write one clears", v & 32'h1, 32'h0);
            resp_claim = 1'b1;

            // long response, writes while busy
            ack_delay = 4;
            resp_data = 32'h0BAD_F00D;
            wr(3'd0, 32'h0000_0100, 0);
            r0 = req_rises;
            addr_moves = 0;
            wr(3'd1, 32'h0000_000A, 1);
            wr(3'd0, 32'h0000_DEAD, 0);
            wr(3'd1, 32'h0000_00F6, 0);
            reg_sel = 3'd4; #1;
            chk("R10 status busy", reg_rdata & 32'h2, 32'h2);
            waitn(6);
            chk("R10 single launch", 32'(req_rises - r0), 32'd1);
            chk("R12 addr steady", 32'(addr_moves), 32'd0);
            rd(3'd0, v); chk("R10 addr ignored", v, 32'h0000_0100);
            rd(3'd1, v); chk("R10 cmd ignored", v, 32'h0000_000A);
            rd(3'd3, v); chk("R1 delayed data", v, 32'h0BAD_F00D);
            ack_delay = 0;
            waitn(2);
         end
         begin
            wait (timed_out);
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      model_on = 0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule